// File: doc/BRIEF.md
# Reorder-Buffer Head with Precise Trap Sequencing

This block is the oldest end of a reorder buffer. Micro-ops are inserted in program order at the tail and receive a tag; execution units later report each one through a writeback port as either finished normally or faulted. A faulted report carries a cause number and an auxiliary word, such as the faulting address and the access kind. Micro-ops that never need execution, like decode faults or injected interrupts, can be inserted already finished or already faulted. A scheduler sees only the entries that are valid and still waiting.

Retirement looks only at the head entry and handles at most one entry per cycle. A finished head commits its PC and is freed. A faulted head is never committed. The block drops every entry in flight, including the faulting one, and broadcasts one cancel-all pulse so that speculative state elsewhere snaps back to committed state. It copies the restart context (PC, stack pointer, flags, privilege) and the fault details into privileged registers. It holds fetch, then redirects it to a handler PC and stack pointer picked by the cause from a small vector table, and enters supervisor mode.

The sequencer has three states. RUN is normal retirement. TRAP lasts one cycle and drives the cancel pulse. VECTOR lasts one cycle and drives the redirect. The transitions are: RUN→TRAP when the valid head is faulted (take_trap), TRAP→VECTOR unconditionally (purge_done), and VECTOR→RUN unconditionally (redirect_done, which also sets supervisor mode). Every other case stays in RUN.

Top module: `rob_retire`

## Requirements
- R1: After reset the buffer is empty, no commit, cancel, halt or redirect is driven, the privilege is user (priv_super=0), alloc_ready=1 and issue_mask=0.
- R2: Entries commit in insertion order, one per cycle, even when their writebacks arrive out of order. commit_pc gives the PC of the committing entry.
- R3: While the head entry is valid but not finished, nothing commits, whatever the state of younger entries.
- R4: A faulted entry at the head never commits. In the cycle after it is seen in RUN, cancel_all is high for exactly one cycle, and fetch_halt is high from then until the redirect cycle has passed.
- R5: The trap purges every entry. In the cancel cycle issue_mask is 0, and no younger entry ever commits, even one that had already finished.
- R6: In the cancel cycle, sav_pc holds the faulting PC, sav_cause and sav_aux hold the fault details, and sav_sp, sav_flags and sav_priv hold cur_sp, cur_flags and the privilege in effect before the trap.
- R7: In the cycle after cancel, redirect_valid is 1 and redirect_pc and redirect_sp come from vector slot cause. A cause of VEC_N or more uses the default slot, at index VEC_N.
- R8: In the cycle after redirect, priv_super is 1 and fetch_halt is 0.
- R9: An entry inserted with alloc_done=1 never appears in issue_mask and commits with no writeback. An entry inserted with alloc_exc=1 traps with alloc_cause at the head.
- R10: alloc_ready is 0 while the buffer holds DEPTH entries or the state is not RUN, and an insertion attempted then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Insert a micro-op at the tail |
| alloc_pc | input | XLEN | PC of inserted micro-op |
| alloc_done | input | 1 | Insert already finished (not scheduled) |
| alloc_exc | input | 1 | Insert already faulted |
| alloc_cause | input | CW | Cause for a pre-faulted insert |
| alloc_ready | output | 1 | Insertion accepted this cycle |
| alloc_tag | output | log2(DEPTH) | Tag given to the next insertion |
| wb_valid | input | 1 | Writeback report |
| wb_tag | input | log2(DEPTH) | Tag being reported |
| wb_exc | input | 1 | Report is a fault |
| wb_cause | input | CW | Fault cause number |
| wb_aux | input | AUXW | Fault auxiliary word |
| issue_mask | output | DEPTH | Entries valid and still waiting |
| commit_valid | output | 1 | Head commits this cycle |
| commit_pc | output | XLEN | PC being committed |
| cur_sp | input | XLEN | Committed stack pointer |
| cur_flags | input | FLW | Committed flags |
| vec_we | input | 1 | Vector table write |
| vec_idx | input | log2(VEC_N+1) | Vector slot (VEC_N = default) |
| vec_pc | input | XLEN | Handler PC to store |
| vec_sp | input | XLEN | Handler SP to store |
| cancel_all | output | 1 | Purge-everything pulse |
| fetch_halt | output | 1 | Fetch held during trap |
| redirect_valid | output | 1 | Fetch redirect to handler |
| redirect_pc | output | XLEN | Handler PC |
| redirect_sp | output | XLEN | Handler SP |
| priv_super | output | 1 | Supervisor mode |
| sav_pc | output | XLEN | Saved restart PC |
| sav_sp | output | XLEN | Saved stack pointer |
| sav_flags | output | FLW | Saved flags |
| sav_priv | output | 1 | Saved privilege |
| sav_cause | output | CW | Saved cause |
| sav_aux | output | AUXW | Saved auxiliary word |

## Verification
The assertions assume that writeback names only tags that are currently valid and still waiting, and that an insertion is counted only when alloc_ready is high. If those inputs are violated, the no-overflow and purge properties lose their meaning. The stimulus takes its tags only from alloc_tag at insertion time and reports each tag at most once. The single overflow attempt is made while alloc_ready is low and is checked at the ports by confirming that it never commits. Vector slots are programmed before any trap, so the handler addresses seen at redirect are known values.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_TRAP   = 2'd1,
        ST_VECTOR = 2'd2
    } retire_state_t;
endpackage

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int CW    = 4,
    parameter int AUXW  = 32,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_en,
    input  logic [XLEN-1:0] alloc_pc,
    input  logic            alloc_done,
    input  logic            alloc_exc,
    input  logic [CW-1:0]   alloc_cause,
    input  logic            wb_valid,
    input  logic [TW-1:0]   wb_tag,
    input  logic            wb_exc,
    input  logic [CW-1:0]   wb_cause,
    input  logic [AUXW-1:0] wb_aux,
    input  logic            pop,
    input  logic            flush,
    output logic            head_valid,
    output logic            head_done,
    output logic            head_exc,
    output logic [XLEN-1:0] head_pc,
    output logic [CW-1:0]   head_cause,
    output logic [AUXW-1:0] head_aux,
    output logic [TW-1:0]   tail_tag,
    output logic            full,
    output logic [DEPTH-1:0] issue_mask
);
    logic [DEPTH-1:0] ent_v, ent_d, ent_e;
    logic [XLEN-1:0]  ent_pc    [DEPTH];
    logic [CW-1:0]    ent_cause [DEPTH];
    logic [AUXW-1:0]  ent_aux   [DEPTH];
    logic [TW-1:0]    head_q, tail_q;
    logic [TW:0]      cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_d <= '0;
            ent_e <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_pc[i]    <= '0;
                ent_cause[i] <= '0;
                ent_aux[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (flush) begin
                    ent_v[i] <= 1'b0;
                    ent_d[i] <= 1'b0;
                    ent_e[i] <= 1'b0;
                end else if (alloc_en && tail_q == TW'(i)) begin
                    ent_v[i]     <= 1'b1;
                    ent_d[i]     <= alloc_done && !alloc_exc;
                    ent_e[i]     <= alloc_exc;
                    ent_pc[i]    <= alloc_pc;
                    ent_cause[i] <= alloc_cause;
                    ent_aux[i]   <= '0;
                end else if (wb_valid && wb_tag == TW'(i) && ent_v[i] && !ent_d[i] && !ent_e[i]) begin
                    ent_d[i]     <= !wb_exc;
                    ent_e[i]     <= wb_exc;
                    ent_cause[i] <= wb_cause;
                    ent_aux[i]   <= wb_aux;
                end else if (pop && head_q == TW'(i)) begin
                    ent_v[i] <= 1'b0;
                    ent_d[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc_en) tail_q <= tail_q + 1'b1;
            if (pop)      head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + (TW+1)'(alloc_en) - (TW+1)'(pop);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_issue
            assign issue_mask[g] = ent_v[g] && !ent_d[g] && !ent_e[g];
        end
    endgenerate

    assign head_valid = ent_v[head_q];
    assign head_done  = ent_d[head_q];
    assign head_exc   = ent_e[head_q];
    assign head_pc    = ent_pc[head_q];
    assign head_cause = ent_cause[head_q];
    assign head_aux   = ent_aux[head_q];
    assign tail_tag   = tail_q;
    assign full       = (cnt_q == (TW+1)'(DEPTH));

    AST_EMPTY_AFTER_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (issue_mask == '0 && !head_valid)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_en); // R10
endmodule

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
    parameter int VEC_N = 8,
    parameter int XLEN  = 32,
    parameter int CW    = 4,
    localparam int VW   = $clog2(VEC_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [VW-1:0]   widx,
    input  logic [XLEN-1:0] wpc,
    input  logic [XLEN-1:0] wsp,
    input  logic [CW-1:0]   cause,
    output logic [XLEN-1:0] hpc,
    output logic [XLEN-1:0] hsp
);
    logic [XLEN-1:0] pc_t [VEC_N+1];
    logic [XLEN-1:0] sp_t [VEC_N+1];
    logic [VW-1:0]   sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= VEC_N; i++) begin
                pc_t[i] <= '0;
                sp_t[i] <= '0;
            end
        end else if (we && int'(widx) <= VEC_N) begin
            pc_t[widx] <= wpc;
            sp_t[widx] <= wsp;
        end
    end

    always_comb begin
        if (int'(cause) < VEC_N) sel = VW'(cause);
        else                     sel = VW'(VEC_N);
    end

    assign hpc = pc_t[sel];
    assign hsp = sp_t[sel];
endmodule

// File: rtl/retire_fsm.sv
module retire_fsm import rob_pkg::*; #(
    parameter int XLEN = 32,
    parameter int CW   = 4,
    parameter int AUXW = 32,
    parameter int FLW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_valid,
    input  logic            head_done,
    input  logic            head_exc,
    input  logic [XLEN-1:0] head_pc,
    input  logic [CW-1:0]   head_cause,
    input  logic [AUXW-1:0] head_aux,
    input  logic [XLEN-1:0] cur_sp,
    input  logic [FLW-1:0]  cur_flags,
    output logic            pop,
    output logic            flush,
    output logic            in_run,
    output logic            commit_valid,
    output logic [XLEN-1:0] commit_pc,
    output logic            cancel_all,
    output logic            fetch_halt,
    output logic            redirect_valid,
    output logic            priv_super,
    output logic [XLEN-1:0] sav_pc,
    output logic [XLEN-1:0] sav_sp,
    output logic [FLW-1:0]  sav_flags,
    output logic            sav_priv,
    output logic [CW-1:0]   sav_cause,
    output logic [AUXW-1:0] sav_aux
);
    retire_state_t st_q, st_n;
    logic take_trap;

    assign take_trap = (st_q == ST_RUN) && head_valid && head_exc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RUN:    if (take_trap) st_n = ST_TRAP;
            ST_TRAP:   st_n = ST_VECTOR;
            ST_VECTOR: st_n = ST_RUN;
            default:   st_n = ST_RUN;
        endcase
    end

    always_comb begin
        in_run         = 1'b0;
        commit_valid   = 1'b0;
        cancel_all     = 1'b0;
        fetch_halt     = 1'b0;
        redirect_valid = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                in_run       = 1'b1;
                commit_valid = head_valid && head_done && !head_exc;
            end
            ST_TRAP: begin
                cancel_all = 1'b1;
                fetch_halt = 1'b1;
            end
            ST_VECTOR: begin
                fetch_halt     = 1'b1;
                redirect_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign pop       = commit_valid;
    assign flush     = take_trap;
    assign commit_pc = head_pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_super <= 1'b0;
            sav_pc     <= '0;
            sav_sp     <= '0;
            sav_flags  <= '0;
            sav_priv   <= 1'b0;
            sav_cause  <= '0;
            sav_aux    <= '0;
        end else begin
            if (take_trap) begin
                sav_pc    <= head_pc;
                sav_sp    <= cur_sp;
                sav_flags <= cur_flags;
                sav_priv  <= priv_super;
                sav_cause <= head_cause;
                sav_aux   <= head_aux;
            end
            if (st_q == ST_VECTOR) priv_super <= 1'b1;
        end
    end

    AST_COMMIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (head_valid && head_done)); // R3
    AST_NO_COMMIT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_exc) |-> !commit_valid); // R4
    AST_FAULT_THEN_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_exc && !fetch_halt) |=> cancel_all); // R4
    AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_all |=> !cancel_all); // R4
    AST_REDIRECT_AFTER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_all |=> redirect_valid); // R7
    AST_SUPER_AFTER_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (priv_super && !fetch_halt)); // R8
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int CW    = 4,
    parameter int AUXW  = 32,
    parameter int FLW   = 8,
    parameter int VEC_N = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int VW   = $clog2(VEC_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [XLEN-1:0]  alloc_pc,
    input  logic             alloc_done,
    input  logic             alloc_exc,
    input  logic [CW-1:0]    alloc_cause,
    output logic             alloc_ready,
    output logic [TW-1:0]    alloc_tag,
    input  logic             wb_valid,
    input  logic [TW-1:0]    wb_tag,
    input  logic             wb_exc,
    input  logic [CW-1:0]    wb_cause,
    input  logic [AUXW-1:0]  wb_aux,
    output logic [DEPTH-1:0] issue_mask,
    output logic             commit_valid,
    output logic [XLEN-1:0]  commit_pc,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [FLW-1:0]   cur_flags,
    input  logic             vec_we,
    input  logic [VW-1:0]    vec_idx,
    input  logic [XLEN-1:0]  vec_pc,
    input  logic [XLEN-1:0]  vec_sp,
    output logic             cancel_all,
    output logic             fetch_halt,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  redirect_sp,
    output logic             priv_super,
    output logic [XLEN-1:0]  sav_pc,
    output logic [XLEN-1:0]  sav_sp,
    output logic [FLW-1:0]   sav_flags,
    output logic             sav_priv,
    output logic [CW-1:0]    sav_cause,
    output logic [AUXW-1:0]  sav_aux
);
    logic            head_valid, head_done, head_exc;
    logic [XLEN-1:0] head_pc;
    logic [CW-1:0]   head_cause;
    logic [AUXW-1:0] head_aux;
    logic            full, pop, flush, in_run, alloc_en;

    assign alloc_ready = in_run && !full;
    assign alloc_en    = alloc_valid && alloc_ready;

    rob_store #(.DEPTH(DEPTH), .XLEN(XLEN), .CW(CW), .AUXW(AUXW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_pc(alloc_pc), .alloc_done(alloc_done),
        .alloc_exc(alloc_exc), .alloc_cause(alloc_cause),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_exc(wb_exc),
        .wb_cause(wb_cause), .wb_aux(wb_aux),
        .pop(pop), .flush(flush),
        .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
        .head_pc(head_pc), .head_cause(head_cause), .head_aux(head_aux),
        .tail_tag(alloc_tag), .full(full), .issue_mask(issue_mask)
    );

    retire_fsm #(.XLEN(XLEN), .CW(CW), .AUXW(AUXW), .FLW(FLW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
        .head_pc(head_pc), .head_cause(head_cause), .head_aux(head_aux),
        .cur_sp(cur_sp), .cur_flags(cur_flags),
        .pop(pop), .flush(flush), .in_run(in_run),
        .commit_valid(commit_valid), .commit_pc(commit_pc),
        .cancel_all(cancel_all), .fetch_halt(fetch_halt),
        .redirect_valid(redirect_valid), .priv_super(priv_super),
        .sav_pc(sav_pc), .sav_sp(sav_sp), .sav_flags(sav_flags),
        .sav_priv(sav_priv), .sav_cause(sav_cause), .sav_aux(sav_aux)
    );

    trap_vec_table #(.VEC_N(VEC_N), .XLEN(XLEN), .CW(CW)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .we(vec_we), .widx(vec_idx), .wpc(vec_pc), .wsp(vec_sp),
        .cause(sav_cause), .hpc(redirect_pc), .hsp(redirect_sp)
    );
endmodule

// File: tb/test_rob_retire.sv
`timescale 1ns/1ps
module test_rob_retire;
    localparam int DEPTH = 8, XLEN = 32, CW = 4, AUXW = 32, FLW = 8, VEC_N = 8;
    localparam int TW = $clog2(DEPTH), VW = $clog2(VEC_N + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n;

    logic alloc_valid = 0, alloc_done = 0, alloc_exc = 0;
    logic [XLEN-1:0] alloc_pc = '0;
    logic [CW-1:0] alloc_cause = '0;
    logic alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic wb_valid = 0, wb_exc = 0;
    logic [TW-1:0] wb_tag = '0;
    logic [CW-1:0] wb_cause = '0;
    logic [AUXW-1:0] wb_aux = '0;
    logic [DEPTH-1:0] issue_mask;
    logic commit_valid;
    logic [XLEN-1:0] commit_pc;
    logic [XLEN-1:0] cur_sp = 32'h0000_5500;
    logic [FLW-1:0] cur_flags = 8'hA5;
    logic vec_we = 0;
    logic [VW-1:0] vec_idx = '0;
    logic [XLEN-1:0] vec_pc = '0, vec_sp = '0;
    logic cancel_all, fetch_halt, redirect_valid, priv_super, sav_priv;
    logic [XLEN-1:0] redirect_pc, redirect_sp, sav_pc, sav_sp;
    logic [FLW-1:0] sav_flags;
    logic [CW-1:0] sav_cause;
    logic [AUXW-1:0] sav_aux;

    rob_retire #(.DEPTH(DEPTH), .XLEN(XLEN), .CW(CW), .AUXW(AUXW), .FLW(FLW), .VEC_N(VEC_N)) i_rob_retire (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_done(alloc_done),
        .alloc_exc(alloc_exc), .alloc_cause(alloc_cause),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_exc(wb_exc),
        .wb_cause(wb_cause), .wb_aux(wb_aux),
        .issue_mask(issue_mask), .commit_valid(commit_valid), .commit_pc(commit_pc),
        .cur_sp(cur_sp), .cur_flags(cur_flags),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_pc(vec_pc), .vec_sp(vec_sp),
        .cancel_all(cancel_all), .fetch_halt(fetch_halt),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .redirect_sp(redirect_sp),
        .priv_super(priv_super), .sav_pc(sav_pc), .sav_sp(sav_sp), .sav_flags(sav_flags),
        .sav_priv(sav_priv), .sav_cause(sav_cause), .sav_aux(sav_aux)
    );

    int checks = 0, errors = 0;
    logic [XLEN-1:0] clog [0:255];
    int ncom = 0;

    always @(posedge clk) begin
        if (rst_n && commit_valid) begin
            clog[ncom[7:0]] = commit_pc;
            ncom = ncom + 1;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_alloc(input logic [XLEN-1:0] pc, input logic dn, input logic ex,
                            input logic [CW-1:0] c, output logic [TW-1:0] tag);
        tag = alloc_tag;
        alloc_valid = 1; alloc_pc = pc; alloc_done = dn; alloc_exc = ex; alloc_cause = c;
        @(negedge clk);
        alloc_valid = 0; alloc_done = 0; alloc_exc = 0;
    endtask

    task automatic do_wb(input logic [TW-1:0] tag, input logic ex,
                         input logic [CW-1:0] c, input logic [AUXW-1:0] aux);
        wb_valid = 1; wb_tag = tag; wb_exc = ex; wb_cause = c; wb_aux = aux;
        @(negedge clk);
        wb_valid = 0; wb_exc = 0;
    endtask

    task automatic vec_write(input logic [VW-1:0] idx, input logic [XLEN-1:0] pc, input logic [XLEN-1:0] sp);
        vec_we = 1; vec_idx = idx; vec_pc = pc; vec_sp = sp;
        @(negedge clk);
        vec_we = 0;
    endtask

    task automatic t_reset;
        chk("R1 commit_valid", commit_valid, 0);
        chk("R1 cancel_all", cancel_all, 0);
        chk("R1 fetch_halt", fetch_halt, 0);
        chk("R1 redirect_valid", redirect_valid, 0);
        chk("R1 priv_super", priv_super, 0);
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 issue_mask", issue_mask, 0);
    endtask

    task automatic t_in_order;
        logic [TW-1:0] a, b, c;
        int base;
        base = ncom;
        do_alloc(32'h100, 0, 0, 0, a);
        do_alloc(32'h104, 0, 0, 0, b);
        do_alloc(32'h108, 0, 0, 0, c);
        do_wb(c, 0, 0, 0);
        tick(1);
        chk("R3 no commit with head waiting (youngest done)", ncom - base, 0);
        do_wb(b, 0, 0, 0);
        tick(1);
        chk("R3 no commit with head waiting (two done)", ncom - base, 0);
        do_wb(a, 0, 0, 0);
        tick(4);
        chk("R2 commit count", ncom - base, 3);
        chk("R2 first commit pc", clog[base[7:0]], 32'h100);
        chk("R2 second commit pc", clog[8'(base + 1)], 32'h104);
        chk("R2 third commit pc", clog[8'(base + 2)], 32'h108);
    endtask

    task automatic t_predone;
        logic [TW-1:0] n, p;
        int base;
        base = ncom;
        do_alloc(32'h300, 0, 0, 0, n);
        do_alloc(32'h304, 1, 0, 0, p);
        chk("R9 waiting entry in issue_mask", issue_mask[n], 1);
        chk("R9 pre-done entry not in issue_mask", issue_mask[p], 0);
        do_wb(n, 0, 0, 0);
        tick(3);
        chk("R9 commit count", ncom - base, 2);
        chk("R9 pre-done commits without writeback", clog[8'(base + 1)], 32'h304);
    endtask

    task automatic t_trap;
        logic [TW-1:0] a, b, c;
        int base;
        do_alloc(32'h200, 0, 0, 0, a);
        do_alloc(32'h204, 0, 0, 0, b);
        do_alloc(32'h208, 0, 0, 0, c);
        do_wb(b, 0, 0, 0);
        do_wb(c, 0, 0, 0);
        base = ncom;
        do_wb(a, 1, 4'd3, 32'hBEEF);
        chk("R4 faulted head not committed", commit_valid, 0);
        chk("R4 no cancel before trap cycle", cancel_all, 0);
        tick(1);
        chk("R4 cancel_all high", cancel_all, 1);
        chk("R4 fetch_halt high", fetch_halt, 1);
        chk("R10 alloc_ready low during trap", alloc_ready, 0);
        chk("R5 issue_mask empty", issue_mask, 0);
        chk("R6 sav_pc", sav_pc, 32'h200);
        chk("R6 sav_cause", sav_cause, 3);
        chk("R6 sav_aux", sav_aux, 32'hBEEF);
        chk("R6 sav_sp", sav_sp, 32'h5500);
        chk("R6 sav_flags", sav_flags, 8'hA5);
        chk("R6 sav_priv", sav_priv, 0);
        tick(1);
        chk("R4 cancel_all single cycle", cancel_all, 0);
        chk("R4 fetch_halt still high", fetch_halt, 1);
        chk("R7 redirect_valid", redirect_valid, 1);
        chk("R7 redirect_pc", redirect_pc, 32'h3000);
        chk("R7 redirect_sp", redirect_sp, 32'h3100);
        tick(1);
        chk("R8 priv_super", priv_super, 1);
        chk("R8 fetch_halt released", fetch_halt, 0);
        tick(3);
        chk("R5 younger done entries never commit", ncom - base, 0);
    endtask

    task automatic t_default_vec;
        logic [TW-1:0] x;
        do_alloc(32'h500, 0, 1, 4'd12, x);
        chk("R9 pre-faulted head not committed", commit_valid, 0);
        tick(1);
        chk("R9 pre-faulted insert traps", cancel_all, 1);
        chk("R9 sav_cause from insert", sav_cause, 12);
        chk("R6 sav_priv supervisor", sav_priv, 1);
        chk("R6 sav_pc", sav_pc, 32'h500);
        tick(1);
        chk("R7 default redirect_pc", redirect_pc, 32'hF000);
        chk("R7 default redirect_sp", redirect_sp, 32'hF100);
        tick(1);
    endtask

    task automatic t_full;
        logic [TW-1:0] tags [DEPTH];
        logic [TW-1:0] dummy;
        int base, found;
        base = ncom;
        for (int i = 0; i < DEPTH; i++) do_alloc(32'h400 + 32'(4 * i), 0, 0, 0, tags[i]);
        chk("R10 alloc_ready low when full", alloc_ready, 0);
        do_alloc(32'h999, 1, 0, 0, dummy);
        for (int i = 0; i < DEPTH; i++) do_wb(tags[i], 0, 0, 0);
        tick(12);
        chk("R10 commit count when full", ncom - base, DEPTH);
        chk("R2 last commit pc", clog[8'(base + DEPTH - 1)], 32'h41C);
        found = 0;
        for (int i = base; i < ncom; i++) if (clog[i[7:0]] == 32'h999) found = 1;
        chk("R10 insertion while full ignored", found, 0);
    endtask

    initial begin
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        vec_write(4'd3, 32'h3000, 32'h3100);
        vec_write(4'd8, 32'hF000, 32'hF100);
        t_in_order();
        t_predone();
        t_trap();
        t_default_vec();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule